// File: doc/BRIEF.md
# Branch Class Decoder

This block sorts one recorded control-flow transfer into a class word. It reads the first opcode byte and the second opcode byte of the source instruction, the reg field of its ModRM byte, the source and destination addresses, and a flag that says whether the instruction bytes could be fetched. From these inputs it yields a twelve-bit class word. Bits 11 to 2 hold one transfer kind. Bits 1 and 0 hold the privilege level of the destination. A zero word means the class is unknown.

The decision depends on two things: the opcode, and the privilege change between source and destination. When a transfer goes from user space into the kernel and the opcode is not a system-call or software-interrupt instruction, the only explanation is an asynchronous event, such as an interrupt, trap or fault. The class is then rewritten to say so. Kernel space is every address at or above a parameterised base; by default the base is the address with only the top bit set. A sampling filter downstream keeps or drops the entry by testing the class word against its request mask.

An input is accepted with `in_valid`. When `REGISTERED` is 1 (the default), the result appears one clock later with `out_valid`. When it is 0, the path is purely combinational.

Top module: `brc_top`

## Requirements
- R1: When the first opcode byte is 0x0F, the second byte decides the class: 0x05 or 0x34 gives syscall (bit 4), 0x07 or 0x35 gives sysret (bit 5), 0x80 through 0x8F gives conditional (bit 8), and every other value is unknown.
- R2: One-byte opcodes map as follows. 0x70–0x7F and 0xE0–0xE3 give conditional (bit 8). 0xC2, 0xC3, 0xCA and 0xCB give return (bit 3). 0xCF gives iret (bit 7). 0xCC–0xCE give software interrupt (bit 6). 0xE8 and 0x9A give call (bit 2). 0xE9–0xEB give jump (bit 9).
- R3: For opcode 0xFF, the ModRM reg field decides the class: 2 or 3 gives indirect call (bit 11), 4 or 5 gives jump (bit 9), and any other value is unknown.
- R4: A zero source address, a zero destination address, or `bytes_ok` low forces the whole class word to zero and raises `unknown`. This holds even for a user-to-kernel transfer.
- R5: A transfer from user to kernel whose opcode class is neither syscall nor software interrupt becomes hw interrupt/fault (bit 10). This includes opcodes that would otherwise be unknown.
- R6: Every class word that is not zero has exactly one privilege bit set, taken from the destination: kernel is bit 1 and user is bit 0.
- R7: An address counts as kernel when it is greater than or equal to `KERNEL_BASE`, and as user when it is below it.
- R8: With `REGISTERED`=1, `out_valid` and the result follow `in_valid` and its operands exactly one clock later. Reset clears `out_valid` and the class word.
- R9: A one-byte opcode not listed in R2 or R3 gives a zero class word with `unknown` high when the transfer stays at the same level or goes from kernel to user.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands present this cycle |
| src_addr | input | ADDR_W | Address of the source instruction |
| dst_addr | input | ADDR_W | Destination address |
| op0 | input | 8 | First opcode byte |
| op1 | input | 8 | Second opcode byte (used after 0x0F) |
| modrm_reg | input | 3 | Bits 5:3 of the ModRM byte |
| bytes_ok | input | 1 | Instruction bytes were obtained |
| out_valid | output | 1 | Result present |
| class_word | output | 12 | Class and privilege bits, zero when unknown |
| unknown | output | 1 | Result is unknown |

## Verification
Every classification is due exactly one clock after the cycle in which its operands are presented with `in_valid`, and an idle input gives an idle output in the next cycle. The driver presents operands just after a falling edge and queues the expected word. The monitor samples on the following falling edge, after the single register stage has updated, and compares against the front of the queue. If `out_valid` rises with nothing queued, or a queued item is never delivered, that counts as a failure. This catches extra or missing latency, not only a wrong class.

// File: rtl/brc_pkg.sv
package brc_pkg;

    localparam int CLS_W = 12;

    // class word bit positions
    localparam int B_USER    = 0;
    localparam int B_KERNEL  = 1;
    localparam int B_CALL    = 2;
    localparam int B_RET     = 3;
    localparam int B_SYSCALL = 4;
    localparam int B_SYSRET  = 5;
    localparam int B_SWINT   = 6;
    localparam int B_IRET    = 7;
    localparam int B_COND    = 8;
    localparam int B_JUMP    = 9;
    localparam int B_HWIRQ   = 10;
    localparam int B_INDCALL = 11;

    typedef logic [CLS_W-1:0] cls_t;

    typedef struct packed {
        logic vld;
        cls_t cls;
        logic unk;
    } brc_res_t;

    function automatic cls_t cls_bit(input int pos);
        cls_t v;
        v = '0;
        v[pos] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/brc_priv_cmp.sv
module brc_priv_cmp #(
    parameter int                ADDR_W      = 32,
    parameter logic [ADDR_W-1:0] KERNEL_BASE = {1'b1, {(ADDR_W-1){1'b0}}}
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              is_kernel,
    output logic              is_zero
);
    always_comb begin
        is_kernel = (addr >= KERNEL_BASE);
        is_zero   = (addr == '0);
    end
endmodule

// File: rtl/brc_opcode_dec.sv
module brc_opcode_dec
    import brc_pkg::*;
(
    input  logic [7:0] op0,
    input  logic [7:0] op1,
    input  logic [2:0] modrm_reg,
    output cls_t       raw_cls
);
    cls_t esc_cls;
    cls_t grp_cls;

    // second byte after the 0x0F escape
    always_comb begin
        case (op1) inside
            8'h05, 8'h34:   esc_cls = cls_bit(B_SYSCALL);
            8'h07, 8'h35:   esc_cls = cls_bit(B_SYSRET);
            [8'h80:8'h8F]:  esc_cls = cls_bit(B_COND);
            default:        esc_cls = '0;
        endcase
    end

    // 0xFF group selected by the ModRM reg field
    always_comb begin
        case (modrm_reg)
            3'd2, 3'd3: grp_cls = cls_bit(B_INDCALL);
            3'd4, 3'd5: grp_cls = cls_bit(B_JUMP);
            default:    grp_cls = '0;
        endcase
    end

    always_comb begin
        case (op0) inside
            8'h0F:                       raw_cls = esc_cls;
            [8'h70:8'h7F]:               raw_cls = cls_bit(B_COND);
            [8'hE0:8'hE3]:               raw_cls = cls_bit(B_COND);
            8'hC2, 8'hC3, 8'hCA, 8'hCB:  raw_cls = cls_bit(B_RET);
            8'hCF:                       raw_cls = cls_bit(B_IRET);
            [8'hCC:8'hCE]:               raw_cls = cls_bit(B_SWINT);
            8'hE8, 8'h9A:                raw_cls = cls_bit(B_CALL);
            [8'hE9:8'hEB]:               raw_cls = cls_bit(B_JUMP);
            8'hFF:                       raw_cls = grp_cls;
            default:                     raw_cls = '0;
        endcase
    end
endmodule

// File: rtl/brc_merge.sv
module brc_merge
    import brc_pkg::*;
(
    input  cls_t raw_cls,
    input  logic src_kernel,
    input  logic dst_kernel,
    input  logic src_zero,
    input  logic dst_zero,
    input  logic bytes_ok,
    output cls_t cls,
    output logic unk
);
    logic ring_entry;
    logic entry_instr;
    cls_t kind;

    always_comb begin
        ring_entry  = !src_kernel && dst_kernel;
        entry_instr = raw_cls[B_SYSCALL] || raw_cls[B_SWINT];

        kind = raw_cls;
        if (ring_entry && !entry_instr)
            kind = cls_bit(B_HWIRQ);
        if (!bytes_ok || src_zero || dst_zero)
            kind = '0;

        cls = kind;
        if (kind != '0) begin
            if (dst_kernel) cls[B_KERNEL] = 1'b1;
            else            cls[B_USER]   = 1'b1;
        end
        unk = (kind == '0);
    end
endmodule

// File: rtl/brc_top.sv
module brc_top
    import brc_pkg::*;
#(
    parameter int                ADDR_W      = 32,
    parameter logic [ADDR_W-1:0] KERNEL_BASE = {1'b1, {(ADDR_W-1){1'b0}}},
    parameter bit                REGISTERED  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [ADDR_W-1:0] dst_addr,
    input  logic [7:0]        op0,
    input  logic [7:0]        op1,
    input  logic [2:0]        modrm_reg,
    input  logic              bytes_ok,
    output logic              out_valid,
    output logic [CLS_W-1:0]  class_word,
    output logic              unknown
);
    logic     src_k, dst_k, src_z, dst_z;
    cls_t     raw_cls, mrg_cls;
    logic     mrg_unk;
    brc_res_t res_d, res_q;

    brc_priv_cmp #(.ADDR_W(ADDR_W), .KERNEL_BASE(KERNEL_BASE)) u_src_cmp (
        .addr(src_addr), .is_kernel(src_k), .is_zero(src_z)
    );

    brc_priv_cmp #(.ADDR_W(ADDR_W), .KERNEL_BASE(KERNEL_BASE)) u_dst_cmp (
        .addr(dst_addr), .is_kernel(dst_k), .is_zero(dst_z)
    );

    brc_opcode_dec u_dec (
        .op0(op0), .op1(op1), .modrm_reg(modrm_reg), .raw_cls(raw_cls)
    );

    brc_merge u_merge (
        .raw_cls(raw_cls), .src_kernel(src_k), .dst_kernel(dst_k),
        .src_zero(src_z), .dst_zero(dst_z), .bytes_ok(bytes_ok),
        .cls(mrg_cls), .unk(mrg_unk)
    );

    always_comb begin
        res_d     = '0;
        res_d.vld = in_valid;
        if (in_valid) begin
            res_d.cls = mrg_cls;
            res_d.unk = mrg_unk;
        end
    end

    generate
        if (REGISTERED) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) res_q <= '0;
                else        res_q <= res_d;
            end
        end else begin : g_comb
            assign res_q = res_d;
        end
    endgenerate

    assign out_valid  = res_q.vld;
    assign class_word = res_q.cls;
    assign unknown    = res_q.unk;
endmodule

// File: rtl/brc_checker.sv
module brc_checker
    import brc_pkg::*;
#(
    parameter int                ADDR_W      = 32,
    parameter logic [ADDR_W-1:0] KERNEL_BASE = {1'b1, {(ADDR_W-1){1'b0}}},
    parameter bit                REGISTERED  = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [ADDR_W-1:0] src_addr,
    input logic [ADDR_W-1:0] dst_addr,
    input logic [7:0]        op0,
    input logic              bytes_ok,
    input logic              out_valid,
    input logic [CLS_W-1:0]  class_word,
    input logic              unknown
);
    a_r4_unknown_zero: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (unknown == (class_word == '0)));

    a_r6_one_priv: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !unknown) |-> ($countones(class_word[1:0]) == 1));

    a_r2_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !unknown) |-> ($countones(class_word[CLS_W-1:2]) == 1));

    a_r5_hwirq_kernel: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && class_word[B_HWIRQ]) |-> class_word[B_KERNEL]);

    generate
        if (REGISTERED) begin : g_seq
            a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid);

            a_r8_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> !out_valid);

            a_r4_missing_bytes: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && !bytes_ok) |=> unknown);

            a_r7_kernel_target: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && bytes_ok && src_addr != '0 && dst_addr >= KERNEL_BASE
                 && op0 == 8'hE8) |=> (class_word[B_KERNEL] && !class_word[B_USER]));
        end
    endgenerate
endmodule

bind brc_top brc_checker #(
    .ADDR_W(ADDR_W), .KERNEL_BASE(KERNEL_BASE), .REGISTERED(REGISTERED)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_addr(src_addr),
    .dst_addr(dst_addr), .op0(op0), .bytes_ok(bytes_ok),
    .out_valid(out_valid), .class_word(class_word), .unknown(unknown)
);

// File: tb/brc_top_test.sv
`timescale 1ns/1ps
module brc_top_test;
    localparam logic [31:0] KB = 32'h8000_0000;
    localparam logic [31:0] UA = 32'h0000_1000;
    localparam logic [31:0] KA = 32'h8000_1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] src_addr = '0, dst_addr = '0;
    logic [7:0]  op0 = '0, op1 = '0;
    logic [2:0]  modrm_reg = '0;
    logic        bytes_ok = 1'b0;
    logic        out_valid, unknown;
    logic [11:0] class_word;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    typedef struct { logic [11:0] cls; string tag; } exp_t;
    exp_t q[$];

    always #10 clk = ~clk;

    brc_top uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_addr(src_addr),
        .dst_addr(dst_addr), .op0(op0), .op1(op1), .modrm_reg(modrm_reg),
        .bytes_ok(bytes_ok), .out_valid(out_valid), .class_word(class_word),
        .unknown(unknown)
    );

    // reference: built from the requirement list
    function automatic logic [11:0] ref_cls(input logic [7:0] a, input logic [7:0] b,
                                            input logic [2:0] r, input logic [31:0] s,
                                            input logic [31:0] d, input logic ok);
        logic [11:0] k;
        k = 12'h000;
        if (a == 8'h0F) begin
            if (b == 8'h05 || b == 8'h34) k = 12'h010;
            else if (b == 8'h07 || b == 8'h35) k = 12'h020;
            else if (b >= 8'h80 && b <= 8'h8F) k = 12'h100;
        end else if ((a >= 8'h70 && a <= 8'h7F) || (a >= 8'hE0 && a <= 8'hE3)) k = 12'h100;
        else if (a == 8'hC2 || a == 8'hC3 || a == 8'hCA || a == 8'hCB) k = 12'h008;
        else if (a == 8'hCF) k = 12'h080;
        else if (a >= 8'hCC && a <= 8'hCE) k = 12'h040;
        else if (a == 8'hE8 || a == 8'h9A) k = 12'h004;
        else if (a >= 8'hE9 && a <= 8'hEB) k = 12'h200;
        else if (a == 8'hFF) begin
            if (r == 3'd2 || r == 3'd3) k = 12'h800;
            else if (r == 3'd4 || r == 3'd5) k = 12'h200;
        end
        if (s < KB && d >= KB && k != 12'h010 && k != 12'h040) k = 12'h400;
        if (!ok || s == 0 || d == 0) k = 12'h000;
        if (k != 0) k = k | ((d >= KB) ? 12'h002 : 12'h001);
        return k;
    endfunction

    task automatic drive(input logic [7:0] a, input logic [7:0] b, input logic [2:0] r,
                         input logic [31:0] s, input logic [31:0] d, input logic ok,
                         input logic [11:0] exp_cls, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1; op0 = a; op1 = b; modrm_reg = r;
        src_addr = s; dst_addr = d; bytes_ok = ok;
        e.cls = exp_cls; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            checks++;
            if (q.size() == 0) begin
                fails++;
                $display("FAIL R8 unexpected result act=%h exp=none", class_word);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (class_word !== e.cls || unknown !== (e.cls == 0)) begin
                    fails++;
                    $display("FAIL %s act=%h/unk%0b exp=%h/unk%0b",
                             e.tag, class_word, unknown, e.cls, (e.cls == 0));
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !done) begin
            fails++;
            $display("FAIL watchdog act=hung exp=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || class_word !== 12'h000) begin
            fails++;
            $display("FAIL R8 reset act=%b/%h exp=0/000", out_valid, class_word);
        end
        rst_n = 1'b1;

        // R1 escape byte group
        drive(8'h0F, 8'h05, 0, UA, KA, 1, 12'h012, "R1 syscall 05");
        drive(8'h0F, 8'h34, 0, KA, KA, 1, 12'h012, "R1 syscall 34");
        drive(8'h0F, 8'h07, 0, KA, UA, 1, 12'h021, "R1 sysret 07");
        drive(8'h0F, 8'h35, 0, KA, UA, 1, 12'h021, "R1 sysret 35");
        drive(8'h0F, 8'h80, 0, UA, UA, 1, 12'h101, "R1 cond 80");
        drive(8'h0F, 8'h8F, 0, KA, KA, 1, 12'h102, "R1 cond 8F");
        drive(8'h0F, 8'h90, 0, UA, UA, 1, 12'h000, "R1 unknown 90");
        // R2 one-byte
        drive(8'h74, 0, 0, KA, KA, 1, 12'h102, "R2 cond 74");
        drive(8'hE2, 0, 0, UA, UA, 1, 12'h101, "R2 loop E2");
        drive(8'hC3, 0, 0, KA, UA, 1, 12'h009, "R2 ret C3");
        drive(8'hCB, 0, 0, KA, KA, 1, 12'h00A, "R2 ret CB");
        drive(8'hCF, 0, 0, KA, UA, 1, 12'h081, "R2 iret");
        drive(8'hCC, 0, 0, UA, UA, 1, 12'h041, "R2 int CC");
        drive(8'hE8, 0, 0, UA, UA, 1, 12'h005, "R2 call E8");
        drive(8'h9A, 0, 0, KA, KA, 1, 12'h006, "R2 call 9A");
        drive(8'hEB, 0, 0, KA, KA, 1, 12'h202, "R2 jump EB");
        // R3 group
        drive(8'hFF, 0, 3'd2, UA, UA, 1, 12'h801, "R3 indcall 2");
        drive(8'hFF, 0, 3'd3, KA, KA, 1, 12'h802, "R3 indcall 3");
        drive(8'hFF, 0, 3'd4, UA, UA, 1, 12'h201, "R3 jump 4");
        drive(8'hFF, 0, 3'd5, KA, UA, 1, 12'h201, "R3 jump 5");
        drive(8'hFF, 0, 3'd6, UA, UA, 1, 12'h000, "R3 unknown 6");
        drive(8'hFF, 0, 3'd0, KA, KA, 1, 12'h000, "R3 unknown 0");
        // R4 missing data
        drive(8'hE8, 0, 0, 32'h0, UA, 1, 12'h000, "R4 src zero");
        drive(8'hE8, 0, 0, UA, 32'h0, 1, 12'h000, "R4 dst zero");
        drive(8'hE8, 0, 0, UA, KA, 0, 12'h000, "R4 bytes missing");
        // R5 ring entry override
        drive(8'hE8, 0, 0, UA, KA, 1, 12'h402, "R5 call to irq");
        drive(8'h0F, 8'h90, 0, UA, KA, 1, 12'h402, "R5 unknown to irq");
        drive(8'hCD, 0, 0, UA, KA, 1, 12'h042, "R5 int kept");
        drive(8'hE8, 0, 0, KA, UA, 1, 12'h005, "R6 kernel to user call");
        // R7 boundary
        drive(8'hE8, 0, 0, KA, KB - 1, 1, 12'h005, "R7 below base user");
        drive(8'hE8, 0, 0, KA, KB, 1, 12'h006, "R7 at base kernel");
        drive(8'hE8, 0, 0, KB - 1, KB, 1, 12'h402, "R7 src below base");
        idle();
        idle();
        // R9 / R2 sweep over every first byte
        for (int i = 0; i < 256; i++) begin
            drive(i[7:0], 8'h84, 3'd4, UA, UA, 1,
                  ref_cls(i[7:0], 8'h84, 3'd4, UA, UA, 1'b1), "R9 sweep");
            if (i % 37 == 0) idle();
        end
        for (int i = 0; i < 8; i++)
            drive(8'hFF, 0, i[2:0], KA, UA, 1, ref_cls(8'hFF, 0, i[2:0], KA, UA, 1'b1), "R3 sweep");
        idle();
        repeat (4) @(negedge clk);
        checks++;
        if (q.size() != 0) begin
            fails++;
            $display("FAIL R8 undelivered act=%0d exp=0", q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule